// File: doc/BRIEF.md
# Write-First Dual-Port Synchronous RAM

This block is a single-clock memory of `2**A_W` words of `D_W` bits with two symmetric ports, A and B. Each port can read or write in any cycle, and each has its own address, write data, write strobe and registered read output. One shared enable gates the whole macro. When the enable is low, no write is performed and both outputs keep their values.

Every read and every write is synchronous. A read returns data on the clock edge after the address is presented. A port that writes sees its own write data on its output in the next cycle. A port that reads the address the other port is writing sees the newly written word, not the old contents. When both ports write one address in the same cycle, the stored word and both outputs are unspecified. This implementation keeps port B's word, but callers must not rely on that.

The storage array is not initialised. Reset clears only the two output registers and blocks writes while it is held.

Top module: `tdpram_wf`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `rdata_a` and `rdata_b` become all zeros in that edge.
- R2: When `en` is low at an edge, no word of the array changes and both outputs keep the value they had before that edge, regardless of the write strobes, addresses and data.
- R3: With `en` high and a port's strobe low, that port's output after the edge equals the last value written to its address, with a latency of exactly one edge.
- R4: With `en` high and a port's strobe high, the word is stored at that port's address, and that port's output after the edge equals its own write data.
- R5: With `en` high, when one port writes and the other port reads the same address, the reading port's output after the edge equals the writing port's data.
- R6: With `en` high and both strobes high on different addresses, both words are stored, and each output shows its own port's write data. This includes address 0 and address `2**A_W-1`.
- R7: With `en` high, both strobes low and equal addresses, both outputs after the edge carry the same stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the output registers; blocks writes |
| en | input | 1 | Enable for the whole memory; low freezes contents and outputs |
| wr_a | input | 1 | Write strobe, port A |
| wr_b | input | 1 | Write strobe, port B |
| addr_a | input | A_W | Word address, port A |
| addr_b | input | A_W | Word address, port B |
| wdata_a | input | D_W | Write data, port A |
| wdata_b | input | D_W | Write data, port B |
| rdata_a | output | D_W | Registered read data, port A |
| rdata_b | output | D_W | Registered read data, port B |

## Verification
The assertions check the following on every clock:
- the outputs hold while the enable is low;
- the output is zero after reset;
- a writing port sees its own data;
- a read that collides with the other port's write is forwarded the new data.

Whether a plain read returns the correct stored word, and whether a disabled cycle really leaves the array untouched, needs memory history. Only the bench's reference model can show these. The bench drives directed sequences at the lowest and highest addresses, then random traffic that favours equal addresses. It reads back every word that a disabled cycle tried to overwrite.

// File: rtl/tdpram_pkg.sv
// Shared types for the write-first dual-port RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package tdpram_pkg;

    // Source selected for one port's output register on an enabled edge.
    typedef enum logic [1:0] {
        SRC_ARRAY = 2'd0,   // word currently stored in the array
        SRC_OWN   = 2'd1,   // this port's own write data
        SRC_PEER  = 2'd2    // other port's write data (collision bypass)
    } out_src_e;

    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/tdpram_ctrl.sv
// Command decode for both ports.
// Produces the write strobes for the array, the capture enable for the
// output registers and, per port, the source of the next output word.
// Assumes: addresses are stable around the clock edge; a same-address
// double write is unspecified and is left to the array's priority.
module tdpram_ctrl
    import tdpram_pkg::*;
#(
    parameter int unsigned A_W = 6
) (
    input  logic           rst_n,
    input  logic           en,
    input  logic           wr_a,
    input  logic           wr_b,
    input  logic [A_W-1:0] addr_a,
    input  logic [A_W-1:0] addr_b,
    output logic           we_a,
    output logic           we_b,
    output logic           cap_en,
    output out_src_e       src_a,
    output out_src_e       src_b
);

    logic same_addr;

    // Address comparator shared by both bypass paths.
    always_comb same_addr = (addr_a == addr_b);

    // Array write strobes: only in enabled cycles outside reset.
    always_comb begin
        we_a = rst_n & en & wr_a;
        we_b = rst_n & en & wr_b;
    end

    // Output registers load on every enabled cycle.
    always_comb cap_en = en;

    // Port A output source: own write, forwarded peer write, or array.
    always_comb begin
        if (wr_a)                   src_a = SRC_OWN;
        else if (wr_b && same_addr) src_a = SRC_PEER;
        else                        src_a = SRC_ARRAY;
    end

    // Port B output source: mirror of port A.
    always_comb begin
        if (wr_b)                   src_b = SRC_OWN;
        else if (wr_a && same_addr) src_b = SRC_PEER;
        else                        src_b = SRC_ARRAY;
    end

endmodule

// File: rtl/tdpram_array.sv
// Storage of 2**A_W words with two write ports and two combinational
// read taps. Port B's write is applied after port A's, so port B wins
// a same-address double write (an implementation choice only).
// Assumes: no reset of the contents; unwritten words are X.
module tdpram_array #(
    parameter int unsigned A_W = 6,
    parameter int unsigned D_W = 16
) (
    input  logic           clk,
    input  logic           we_a,
    input  logic           we_b,
    input  logic [A_W-1:0] addr_a,
    input  logic [A_W-1:0] addr_b,
    input  logic [D_W-1:0] wdata_a,
    input  logic [D_W-1:0] wdata_b,
    output logic [D_W-1:0] tap_a,
    output logic [D_W-1:0] tap_b
);

    localparam int unsigned DEPTH = 1 << A_W;

    logic [D_W-1:0] mem [DEPTH];

    // Write both ports; the later statement gives port B priority.
    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= wdata_a;
        if (we_b) mem[addr_b] <= wdata_b;
    end

    // Read taps of the current contents, registered downstream.
    always_comb begin
        tap_a = mem[addr_a];
        tap_b = mem[addr_b];
    end

endmodule

// File: rtl/tdpram_outreg.sv
// Registered read output of one port, with the write-first selector.
// Assumes: sel is decoded for this port; cap_en is the global enable.
module tdpram_outreg
    import tdpram_pkg::*;
#(
    parameter int unsigned D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  out_src_e       sel,
    input  logic [D_W-1:0] arr_word,
    input  logic [D_W-1:0] own_word,
    input  logic [D_W-1:0] peer_word,
    output logic [D_W-1:0] q
);

    logic [D_W-1:0] next_word;

    // Pick the word that the port should see after this edge.
    always_comb begin
        unique case (sel)
            SRC_OWN:  next_word = own_word;
            SRC_PEER: next_word = peer_word;
            default:  next_word = arr_word;
        endcase
    end

    // Output register: cleared by reset, held while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= next_word;
    end

endmodule

// File: rtl/tdpram_wf.sv
// Top of the write-first dual-port RAM: decode, storage and one
// output register per port, built from a generate loop over ports.
// Assumes: one clock; reset is synchronous and active low.
module tdpram_wf
    import tdpram_pkg::*;
#(
    parameter int unsigned A_W = 6,
    parameter int unsigned D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           wr_a,
    input  logic           wr_b,
    input  logic [A_W-1:0] addr_a,
    input  logic [A_W-1:0] addr_b,
    input  logic [D_W-1:0] wdata_a,
    input  logic [D_W-1:0] wdata_b,
    output logic [D_W-1:0] rdata_a,
    output logic [D_W-1:0] rdata_b
);

    logic                          we_a, we_b, cap_en;
    out_src_e                      sel [NUM_PORTS];
    logic [NUM_PORTS-1:0][D_W-1:0] tap;
    logic [NUM_PORTS-1:0][D_W-1:0] wdat;
    logic [NUM_PORTS-1:0][D_W-1:0] qout;

    // Group per-port data so the output stage can be generated.
    always_comb begin
        wdat[0] = wdata_a;
        wdat[1] = wdata_b;
    end

    tdpram_ctrl #(.A_W(A_W)) ctrl_i (
        .rst_n  (rst_n),
        .en     (en),
        .wr_a   (wr_a),
        .wr_b   (wr_b),
        .addr_a (addr_a),
        .addr_b (addr_b),
        .we_a   (we_a),
        .we_b   (we_b),
        .cap_en (cap_en),
        .src_a  (sel[0]),
        .src_b  (sel[1])
    );

    tdpram_array #(.A_W(A_W), .D_W(D_W)) array_i (
        .clk     (clk),
        .we_a    (we_a),
        .we_b    (we_b),
        .addr_a  (addr_a),
        .addr_b  (addr_b),
        .wdata_a (wdata_a),
        .wdata_b (wdata_b),
        .tap_a   (tap[0]),
        .tap_b   (tap[1])
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        tdpram_outreg #(.D_W(D_W)) outreg_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_en    (cap_en),
            .sel       (sel[p]),
            .arr_word  (tap[p]),
            .own_word  (wdat[p]),
            .peer_word (wdat[NUM_PORTS-1-p]),
            .q         (qout[p])
        );
    end

    // Drive the named output ports.
    always_comb begin
        rdata_a = qout[0];
        rdata_b = qout[1];
    end

endmodule

// File: rtl/tdpram_wf_chk.sv
// Port-level checker for tdpram_wf, attached with bind below.
// Assumes: the double write to one address is unspecified and excluded.
module tdpram_wf_chk #(
    parameter int unsigned A_W = 6,
    parameter int unsigned D_W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           wr_a,
    input logic           wr_b,
    input logic [A_W-1:0] addr_a,
    input logic [A_W-1:0] addr_b,
    input logic [D_W-1:0] wdata_a,
    input logic [D_W-1:0] wdata_b,
    input logic [D_W-1:0] rdata_a,
    input logic [D_W-1:0] rdata_b
);

    logic dbl_same;
    always_comb dbl_same = wr_a && wr_b && (addr_a == addr_b);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (rdata_a == '0 && rdata_b == '0)); // R1

    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(rdata_a) && $stable(rdata_b))); // R2

    AST_OWN_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_a && !dbl_same) |=> (rdata_a == $past(wdata_a))); // R4

    AST_OWN_WRITE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_b && !dbl_same) |=> (rdata_b == $past(wdata_b))); // R4

    AST_FWD_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_a && !wr_b && addr_a == addr_b) |=> (rdata_b == $past(wdata_a))); // R5

    AST_FWD_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_b && !wr_a && addr_a == addr_b) |=> (rdata_a == $past(wdata_b))); // R5

    AST_SAME_READ_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_a && !wr_b && addr_a == addr_b) |=> (rdata_a === rdata_b)); // R7

endmodule

bind tdpram_wf tdpram_wf_chk #(.A_W(A_W), .D_W(D_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .wr_a    (wr_a),
    .wr_b    (wr_b),
    .addr_a  (addr_a),
    .addr_b  (addr_b),
    .wdata_a (wdata_a),
    .wdata_b (wdata_b),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
);

// File: tb/tdpram_wf_tb_top.sv
// Scoreboard bench: the driver predicts each edge's outputs from a
// reference array and queues them; the monitor compares after the edge.
module tdpram_wf_tb_top;

    localparam int unsigned A_W   = 6;
    localparam int unsigned D_W   = 16;
    localparam int unsigned DEPTH = 1 << A_W;
    localparam logic [A_W-1:0] AMAX = A_W'(DEPTH - 1);

    typedef struct {
        logic [D_W-1:0] qa;
        logic [D_W-1:0] qb;
        bit             ka;
        bit             kb;
        string          tag;
    } item_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en = 1'b0, wr_a = 1'b0, wr_b = 1'b0;
    logic [A_W-1:0] addr_a = '0, addr_b = '0;
    logic [D_W-1:0] wdata_a = '0, wdata_b = '0;
    logic [D_W-1:0] rdata_a, rdata_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    item_t          sbq[$];
    logic [D_W-1:0] ref_mem [DEPTH];
    bit             ref_ok  [DEPTH];
    logic [D_W-1:0] exp_a = '0, exp_b = '0;
    bit             kn_a = 1'b1, kn_b = 1'b1;

    always #2 clk = ~clk;

    tdpram_wf #(.A_W(A_W), .D_W(D_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_a(wr_a), .wr_b(wr_b),
        .addr_a(addr_a), .addr_b(addr_b), .wdata_a(wdata_a), .wdata_b(wdata_b),
        .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    task automatic check(input string tag, input string what,
                         input logic [D_W-1:0] act, input logic [D_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue its predicted result.
    task automatic cyc(input bit e, input bit w1, input bit w2,
                       input logic [A_W-1:0] x1, input logic [A_W-1:0] x2,
                       input logic [D_W-1:0] v1, input logic [D_W-1:0] v2,
                       input string tag);
        item_t it;
        bit    clash;
        @(negedge clk);
        en = e; wr_a = w1; wr_b = w2;
        addr_a = x1; addr_b = x2; wdata_a = v1; wdata_b = v2;
        if (e) begin
            clash = w1 && w2 && (x1 == x2);
            if (clash)                 begin kn_a = 1'b0; end
            else if (w1)               begin exp_a = v1; kn_a = 1'b1; end
            else if (w2 && x1 == x2)   begin exp_a = v2; kn_a = 1'b1; end
            else begin exp_a = ref_mem[x1]; kn_a = ref_ok[x1]; end
            if (clash)                 begin kn_b = 1'b0; end
            else if (w2)               begin exp_b = v2; kn_b = 1'b1; end
            else if (w1 && x1 == x2)   begin exp_b = v1; kn_b = 1'b1; end
            else begin exp_b = ref_mem[x2]; kn_b = ref_ok[x2]; end
            if (clash) ref_ok[x1] = 1'b0;
            else begin
                if (w1) begin ref_mem[x1] = v1; ref_ok[x1] = 1'b1; end
                if (w2) begin ref_mem[x2] = v2; ref_ok[x2] = 1'b1; end
            end
        end
        it.qa = exp_a; it.qb = exp_b; it.ka = kn_a; it.kb = kn_b; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: compare each queued prediction just after its clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() != 0) begin
                item_t it;
                it = sbq.pop_front();
                if (it.ka) check(it.tag, "rdata_a", rdata_a, it.qa);
                if (it.kb) check(it.tag, "rdata_b", rdata_b, it.qb);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus: reset, directed scenarios, then biased random traffic.
    initial begin
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
        wr_a = 1'b1; wr_b = 1'b1; en = 1'b1; wdata_a = 16'hDEAD; wdata_b = 16'hBEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rdata_a", rdata_a, '0);
        check("R1", "rdata_b", rdata_b, '0);
        en = 1'b0; wr_a = 1'b0; wr_b = 1'b0;
        rst_n = 1'b1;

        // R4 / R6: fill words through both ports, ends of the range included.
        cyc(1, 1, 1, 6'd0, AMAX, 16'h1000, 16'h1FFF, "R6");
        for (int i = 1; i < 16; i++)
            cyc(1, 1, 0, A_W'(i), AMAX, 16'h2000 + D_W'(i), 16'h0, "R4");
        for (int i = 16; i < 32; i++)
            cyc(1, 0, 1, 6'd0, A_W'(i), 16'h0, 16'h3000 + D_W'(i), "R4");
        // R3: read back on both ports with different addresses.
        for (int i = 0; i < 32; i++)
            cyc(1, 0, 0, A_W'(i), A_W'(31 - i), 16'h0, 16'h0, "R3");
        cyc(1, 0, 0, AMAX, 6'd0, 16'h0, 16'h0, "R3");
        // R7: both ports read one address.
        cyc(1, 0, 0, 6'd5, 6'd5, 16'h0, 16'h0, "R7");
        cyc(1, 0, 0, AMAX, AMAX, 16'h0, 16'h0, "R7");
        // R5: collision bypass in both directions.
        cyc(1, 1, 0, 6'd7, 6'd7, 16'hA5A5, 16'h0, "R5");
        cyc(1, 0, 1, 6'd7, 6'd7, 16'h0, 16'h5A5A, "R5");
        cyc(1, 0, 0, 6'd7, 6'd7, 16'h0, 16'h0, "R5");
        // R2: disabled cycles with write attempts; outputs hold.
        cyc(1, 0, 0, 6'd3, 6'd20, 16'h0, 16'h0, "R3");
        cyc(0, 1, 1, 6'd3, 6'd20, 16'hEEEE, 16'hFFFF, "R2");
        cyc(0, 1, 0, 6'd9, 6'd9, 16'h1111, 16'h0, "R2");
        cyc(0, 0, 0, 6'd1, 6'd2, 16'h0, 16'h0, "R2");
        // R2: contents untouched by the disabled writes.
        cyc(1, 0, 0, 6'd3, 6'd20, 16'h0, 16'h0, "R2");
        cyc(1, 0, 0, 6'd9, 6'd9, 16'h0, 16'h0, "R2");
        // R6: double write on distinct addresses, then read back.
        cyc(1, 1, 1, 6'd40, 6'd41, 16'h4040, 16'h4141, "R6");
        cyc(1, 0, 0, 6'd41, 6'd40, 16'h0, 16'h0, "R6");

        // Random traffic biased toward equal addresses and some idle cycles.
        for (int n = 0; n < 3000; n++) begin
            logic [A_W-1:0] x1, x2;
            bit e, w1, w2;
            x1 = A_W'($urandom_range(0, DEPTH - 1));
            x2 = ($urandom_range(0, 1) == 1) ? x1 : A_W'($urandom_range(0, DEPTH - 1));
            e  = ($urandom_range(0, 4) != 0);
            w1 = ($urandom_range(0, 2) == 0);
            w2 = ($urandom_range(0, 2) == 0);
            cyc(e, w1, w2, x1, x2, D_W'($urandom), D_W'($urandom),
                (x1 == x2) ? "R5" : "R3");
        end

        @(negedge clk);
        en = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule